// File: doc/BRIEF.md
# Supply Monitor Reset Controller

This block is the digital side of a supply-voltage supervisor in a small microcontroller. It takes three comparator flags (supply below the power-on level, below the reset trip level, below the early-warning level), resynchronises them, and turns them into a system reset with a recorded cause. The same reset path also serves software reset requests and a guard on flash programming. A flash erase or write is refused with a dedicated reset when the monitor is not both switched on and chosen as a reset source.

Software controls two persistent bits: the monitor enable and the monitor's selection as a reset source. Only a power-on event or a monitor-triggered reset puts them back to their defaults (both set). Software and flash-error resets leave them as software last wrote them. While the device sleeps, a monitor trip cannot reset it. On wake the stored bits are in force again. After the enable rises, a settling window of configurable length masks the trip. A select written inside that window resets the device. A power-on event holds reset for a parameterised delay. A monitor reset adds no such delay.

Top module: `supmon_rst_ctrl`

## Requirements
- R1: After the cold reset input is released, `sys_rst` is 1, `rst_cause` is 0 (power-on), `por_dly_active` is 1, and `mon_en` and `mon_sel` are both 1.
- R2: While `cmp_below_por` is high, `sys_rst` and `por_dly_active` stay high and the delay counter restarts. After the input falls, the delay lasts POR_DLY cycles plus the two-stage synchroniser. The cause reads 0, and `mon_en`/`mon_sel` return to 1.
- R3: With `mon_en`, `mon_sel`, settling complete and `sleep` low, a high `cmp_below_rst` holds `sys_rst` with cause 1 (supply monitor) for as long as it stays high. `por_dly_active` stays 0 throughout. Afterwards `mon_en` and `mon_sel` are both 1.
- R4: A `src_wr` with `src_swrst_wdata`=1 gives a one-cycle reset with cause 2 (software). The enable and select bits survive it with their software values.
- R5: Every `src_wr` loads the select bit from `src_sel_wdata`. Writing 0 deselects the monitor, and a trip then has no effect.
- R6: A `src_wr` with `src_sel_wdata`=1 while `mon_en` is 0 leaves `mon_sel` at 0.
- R7: For SETTLE_CYC cycles after `mon_en` is written from 0 to 1, the trip is masked. A `src_wr` with `src_sel_wdata`=1 inside that window causes a reset with cause 1.
- R8: While `sleep` is high, a trip causes no reset and the enable and select bits are unchanged. Once `sleep` falls, a trip that is still present resets again.
- R9: A `flash_op` strobe while `mon_en` and `mon_sel` are not both 1 gives a reset with cause 3 (flash error). When both are 1, the strobe causes no reset.
- R10: `vdd_ok` is 0 while `cmp_below_warn` is high and 1 otherwise. `warn_irq` is high exactly when `vdd_ok` is 0 and `warn_ie` is 1.
- R11: `rst_cause` changes only in a cycle where `sys_rst` is high. It holds its value until the next reset.
- R12: When several reset requests arrive in the same cycle, one cause is recorded, by priority power-on > supply monitor > flash error > software.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Cold asynchronous reset, active low |
| cmp_below_por | input | 1 | Comparator: supply below power-on level |
| cmp_below_rst | input | 1 | Comparator: supply below reset trip level |
| cmp_below_warn | input | 1 | Comparator: supply below warning level |
| mon_en_wr | input | 1 | Write strobe for the monitor enable bit |
| mon_en_wdata | input | 1 | Enable value written |
| src_wr | input | 1 | Write strobe for the reset-source register |
| src_sel_wdata | input | 1 | Monitor select bit carried by every source write |
| src_swrst_wdata | input | 1 | Software reset request bit of the source write |
| sleep | input | 1 | Device is in sleep mode |
| flash_op | input | 1 | Flash erase or write strobe |
| warn_ie | input | 1 | Warning interrupt enable |
| sys_rst | output | 1 | System reset, active high |
| rst_cause | output | 2 | Cause of last reset: 0 power-on, 1 monitor, 2 software, 3 flash error |
| por_dly_active | output | 1 | Power-on delay counter running |
| vdd_ok | output | 1 | Supply above warning level |
| warn_irq | output | 1 | Warning interrupt request |
| mon_en | output | 1 | Stored monitor enable |
| mon_sel | output | 1 | Stored monitor select |

## Verification
The flash guard and the software reset both act on the strobe cycle. The bench clears the select bit and then raises `flash_op` in the very cycle of a `src_wr` that requests software reset. It expects a single reset pulse whose cause reads flash error, not software. A second collision asserts the power-on and reset-trip comparators together. The bench judges it by the cause staying at power-on and by `por_dly_active` covering the whole reset.

// File: rtl/supmon_pkg.sv
package supmon_pkg;

    typedef enum logic [1:0] {
        CAUSE_POR   = 2'd0,
        CAUSE_MON   = 2'd1,
        CAUSE_SW    = 2'd2,
        CAUSE_FLASH = 2'd3
    } rst_cause_e;

    typedef struct packed {
        logic       en;
        logic       sel;
        logic       rst;
        rst_cause_e cause;
        logic       vdd_ok;
        logic       irq;
    } ctl_state_t;

endpackage

// File: rtl/supmon_sync.sv
module supmon_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta_d, meta_q;
        logic out_d, out_q;

        always_comb begin
            meta_d = async_i[i];
            out_d  = meta_q;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                out_q  <= 1'b0;
            end else begin
                meta_q <= meta_d;
                out_q  <= out_d;
            end
        end

        assign sync_o[i] = out_q;
    end

endmodule

// File: rtl/supmon_settle.sv
module supmon_settle #(
    parameter int SETTLE_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic force_done,
    output logic done
);

    localparam int CW = $clog2(SETTLE_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          done;
    } settle_t;

    settle_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (force_done) begin
            st_d.done = 1'b1;
            st_d.cnt  = '0;
        end else if (start) begin
            st_d.done = 1'b0;
            st_d.cnt  = '0;
        end else if (!st_q.done) begin
            if (st_q.cnt == LAST) begin
                st_d.done = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0, done: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign done = st_q.done;

endmodule

// File: rtl/supmon_pordly.sv
module supmon_pordly #(
    parameter int POR_DLY = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    output logic active
);

    localparam int CW = $clog2(POR_DLY + 1);
    localparam logic [CW-1:0] LOAD = CW'(POR_DLY);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (hold) begin
            cnt_d = LOAD;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= LOAD;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign active = (cnt_q != '0);

endmodule

// File: rtl/supmon_rst_ctrl.sv
module supmon_rst_ctrl
    import supmon_pkg::*;
#(
    parameter int POR_DLY    = 64,
    parameter int SETTLE_CYC = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmp_below_por,
    input  logic       cmp_below_rst,
    input  logic       cmp_below_warn,
    input  logic       mon_en_wr,
    input  logic       mon_en_wdata,
    input  logic       src_wr,
    input  logic       src_sel_wdata,
    input  logic       src_swrst_wdata,
    input  logic       sleep,
    input  logic       flash_op,
    input  logic       warn_ie,
    output logic       sys_rst,
    output logic [1:0] rst_cause,
    output logic       por_dly_active,
    output logic       vdd_ok,
    output logic       warn_irq,
    output logic       mon_en,
    output logic       mon_sel
);

    localparam int NCMP = 3;
    localparam int IDX_POR  = 0;
    localparam int IDX_RST  = 1;
    localparam int IDX_WARN = 2;

    logic [NCMP-1:0] cmp_raw, cmp_s;
    logic            por_act, settled;
    logic            settle_start, settle_force;

    ctl_state_t st_d, st_q;

    assign cmp_raw[IDX_POR]  = cmp_below_por;
    assign cmp_raw[IDX_RST]  = cmp_below_rst;
    assign cmp_raw[IDX_WARN] = cmp_below_warn;

    supmon_sync #(.W(NCMP)) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(cmp_raw),
        .sync_o (cmp_s)
    );

    supmon_pordly #(.POR_DLY(POR_DLY)) i_pordly (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (cmp_s[IDX_POR]),
        .active(por_act)
    );

    supmon_settle #(.SETTLE_CYC(SETTLE_CYC)) i_settle (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (settle_start),
        .force_done(settle_force),
        .done      (settled)
    );

    logic wr_ok, en_w, src_w, armed, early_sel;
    logic req_por, req_mon, req_flash, req_sw, restore;

    always_comb begin
        wr_ok     = !st_q.rst;
        en_w      = mon_en_wr & wr_ok;
        src_w     = src_wr & wr_ok;
        armed     = st_q.en & st_q.sel & settled & !sleep;
        early_sel = src_w & src_sel_wdata & st_q.en & !settled;

        req_por   = por_act;
        req_mon   = (cmp_s[IDX_RST] & armed) | early_sel;
        req_flash = flash_op & wr_ok & !(st_q.en & st_q.sel);
        req_sw    = src_w & src_swrst_wdata;
        restore   = req_por | req_mon;

        st_d = st_q;

        // persistent enable/select bits
        if (restore) begin
            st_d.en  = 1'b1;
            st_d.sel = 1'b1;
        end else begin
            if (en_w) begin
                st_d.en = mon_en_wdata;
            end
            if (src_w) begin
                st_d.sel = src_sel_wdata & st_q.en;
            end
        end

        settle_force = restore;
        settle_start = en_w & mon_en_wdata & !st_q.en & !restore;

        // reset output and cause, fixed priority
        st_d.rst = req_por | req_mon | req_flash | req_sw;
        if (req_por) begin
            st_d.cause = CAUSE_POR;
        end else if (req_mon) begin
            st_d.cause = CAUSE_MON;
        end else if (req_flash) begin
            st_d.cause = CAUSE_FLASH;
        end else if (req_sw) begin
            st_d.cause = CAUSE_SW;
        end

        // early warning
        st_d.vdd_ok = !cmp_s[IDX_WARN];
        st_d.irq    = warn_ie & cmp_s[IDX_WARN];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{en: 1'b1, sel: 1'b1, rst: 1'b1, cause: CAUSE_POR,
                      vdd_ok: 1'b1, irq: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign sys_rst        = st_q.rst;
    assign rst_cause      = st_q.cause;
    assign por_dly_active = por_act;
    assign vdd_ok         = st_q.vdd_ok;
    assign warn_irq       = st_q.irq;
    assign mon_en         = st_q.en;
    assign mon_sel        = st_q.sel;

endmodule

// File: rtl/supmon_rst_ctrl_chk.sv
module supmon_rst_ctrl_chk
    import supmon_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       src_wr,
    input logic       src_swrst_wdata,
    input logic       sleep,
    input logic       flash_op,
    input logic       sys_rst,
    input logic [1:0] rst_cause,
    input logic       por_dly_active,
    input logic       vdd_ok,
    input logic       warn_irq,
    input logic       mon_en,
    input logic       mon_sel
);

    assert_por_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        por_dly_active |=> (sys_rst && rst_cause == CAUSE_POR));

    assert_mon_no_delay_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_rst && rst_cause == CAUSE_MON) |-> !$past(por_dly_active));

    assert_sw_resets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (src_wr && src_swrst_wdata && !sys_rst) |=> sys_rst);

    assert_sleep_masks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep && !por_dly_active && !flash_op && !src_wr) |=> !sys_rst);

    assert_flash_guard_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (flash_op && !sys_rst && !(mon_en && mon_sel)) |=>
            (sys_rst && rst_cause != CAUSE_SW));

    assert_irq_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        warn_irq |-> !vdd_ok);

    assert_cause_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rst_cause) |-> sys_rst);

endmodule

bind supmon_rst_ctrl supmon_rst_ctrl_chk i_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .src_wr         (src_wr),
    .src_swrst_wdata(src_swrst_wdata),
    .sleep          (sleep),
    .flash_op       (flash_op),
    .sys_rst        (sys_rst),
    .rst_cause      (rst_cause),
    .por_dly_active (por_dly_active),
    .vdd_ok         (vdd_ok),
    .warn_irq       (warn_irq),
    .mon_en         (mon_en),
    .mon_sel        (mon_sel)
);

// File: tb/test_supmon_rst_ctrl.sv
module test_supmon_rst_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int POR_DLY    = 64;
    localparam int SETTLE_CYC = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmp_below_por = 1'b0, cmp_below_rst = 1'b0, cmp_below_warn = 1'b0;
    logic mon_en_wr = 1'b0, mon_en_wdata = 1'b0;
    logic src_wr = 1'b0, src_sel_wdata = 1'b0, src_swrst_wdata = 1'b0;
    logic sleep = 1'b0, flash_op = 1'b0, warn_ie = 1'b0;
    logic sys_rst, por_dly_active, vdd_ok, warn_irq, mon_en, mon_sel;
    logic [1:0] rst_cause;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    supmon_rst_ctrl #(.POR_DLY(POR_DLY), .SETTLE_CYC(SETTLE_CYC)) i_supmon_rst_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cmp_below_por(cmp_below_por), .cmp_below_rst(cmp_below_rst),
        .cmp_below_warn(cmp_below_warn),
        .mon_en_wr(mon_en_wr), .mon_en_wdata(mon_en_wdata),
        .src_wr(src_wr), .src_sel_wdata(src_sel_wdata),
        .src_swrst_wdata(src_swrst_wdata),
        .sleep(sleep), .flash_op(flash_op), .warn_ie(warn_ie),
        .sys_rst(sys_rst), .rst_cause(rst_cause), .por_dly_active(por_dly_active),
        .vdd_ok(vdd_ok), .warn_irq(warn_irq), .mon_en(mon_en), .mon_sel(mon_sel)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 4 * POR_DLY + 50 && sys_rst; i++) tick(1);
        tick(1);
    endtask

    task automatic wr_en(input logic v);
        mon_en_wr = 1'b1; mon_en_wdata = v;
        tick(1);
        mon_en_wr = 1'b0;
    endtask

    task automatic wr_src(input logic sel, input logic swr, input logic fl);
        src_wr = 1'b1; src_sel_wdata = sel; src_swrst_wdata = swr; flash_op = fl;
        tick(1);
        src_wr = 1'b0; src_swrst_wdata = 1'b0; flash_op = 1'b0;
    endtask

    task automatic t_cold_reset();
        tick(1);
        rst_n = 1'b1;
        chk("R1 sys_rst", sys_rst, 1);
        chk("R1 cause", rst_cause, 0);
        chk("R1 por_dly_active", por_dly_active, 1);
        chk("R1 mon_en", mon_en, 1);
        chk("R1 mon_sel", mon_sel, 1);
        wait_idle();
        chk("R1 released", sys_rst, 0);
    endtask

    task automatic t_por_restart();
        int cnt = 0;
        wr_en(1'b0);
        chk("R2 en cleared by sw", mon_en, 0);
        cmp_below_por = 1'b1;
        tick(10);
        chk("R2 held rst", sys_rst, 1);
        chk("R2 held delay", por_dly_active, 1);
        cmp_below_por = 1'b0;
        while (por_dly_active && cnt < 4 * POR_DLY) begin
            tick(1);
            cnt++;
        end
        chk("R2 delay length in range", int'(cnt >= POR_DLY && cnt <= POR_DLY + 3), 1);
        wait_idle();
        chk("R2 cause", rst_cause, 0);
        chk("R2 en restored", mon_en, 1);
        chk("R2 sel restored", mon_sel, 1);
    endtask

    task automatic t_mon_trip();
        cmp_below_rst = 1'b1;
        tick(4);
        chk("R3 rst", sys_rst, 1);
        chk("R3 cause", rst_cause, 1);
        tick(10);
        chk("R3 still held", sys_rst, 1);
        chk("R3 no por delay", por_dly_active, 0);
        cmp_below_rst = 1'b0;
        tick(4);
        chk("R3 released", sys_rst, 0);
        chk("R3 en", mon_en, 1);
        chk("R3 sel", mon_sel, 1);
        tick(5);
        chk("R11 cause held", rst_cause, 1);
    endtask

    task automatic t_sw_reset();
        wr_src(1'b0, 1'b1, 1'b0);
        chk("R4 rst pulse", sys_rst, 1);
        chk("R4 cause", rst_cause, 2);
        tick(1);
        chk("R4 one cycle", sys_rst, 0);
        chk("R4 en kept", mon_en, 1);
        chk("R5 sel written 0", mon_sel, 0);
        cmp_below_rst = 1'b1;
        tick(6);
        chk("R5 deselected trip ignored", sys_rst, 0);
        cmp_below_rst = 1'b0;
        tick(4);
    endtask

    task automatic t_sel_needs_en();
        wr_en(1'b0);
        wr_src(1'b1, 1'b0, 1'b0);
        tick(1);
        chk("R6 sel stays 0", mon_sel, 0);
        chk("R6 no reset", sys_rst, 0);
    endtask

    task automatic t_flash_err();
        flash_op = 1'b1;
        tick(1);
        flash_op = 1'b0;
        chk("R9 flash rst", sys_rst, 1);
        chk("R9 flash cause", rst_cause, 3);
        tick(2);
        chk("R9 en kept 0", mon_en, 0);
        chk("R9 sel kept 0", mon_sel, 0);
    endtask

    task automatic t_settle();
        wr_en(1'b1);
        wr_src(1'b1, 1'b0, 1'b0);
        chk("R7 early select rst", sys_rst, 1);
        chk("R7 early select cause", rst_cause, 1);
        wait_idle();
        chk("R7 en after", mon_en, 1);
        chk("R7 sel after", mon_sel, 1);
        wr_en(1'b0);
        wr_en(1'b1);
        cmp_below_rst = 1'b1;
        tick(6);
        chk("R7 trip masked while settling", sys_rst, 0);
        tick(SETTLE_CYC + 4);
        chk("R7 trip after settle", sys_rst, 1);
        chk("R7 cause after settle", rst_cause, 1);
        cmp_below_rst = 1'b0;
        wait_idle();
    endtask

    task automatic t_flash_ok();
        flash_op = 1'b1;
        tick(1);
        flash_op = 1'b0;
        chk("R9 armed flash no rst", sys_rst, 0);
    endtask

    task automatic t_sleep();
        sleep = 1'b1;
        cmp_below_rst = 1'b1;
        tick(8);
        chk("R8 asleep no rst", sys_rst, 0);
        chk("R8 en kept", mon_en, 1);
        chk("R8 sel kept", mon_sel, 1);
        sleep = 1'b0;
        tick(2);
        chk("R8 wake trip", sys_rst, 1);
        chk("R8 wake cause", rst_cause, 1);
        cmp_below_rst = 1'b0;
        wait_idle();
    endtask

    task automatic t_warn();
        warn_ie = 1'b0;
        cmp_below_warn = 1'b1;
        tick(4);
        chk("R10 vdd_ok low", vdd_ok, 0);
        chk("R10 irq masked", warn_irq, 0);
        warn_ie = 1'b1;
        tick(2);
        chk("R10 irq on", warn_irq, 1);
        cmp_below_warn = 1'b0;
        tick(4);
        chk("R10 vdd_ok back", vdd_ok, 1);
        chk("R10 irq off", warn_irq, 0);
        chk("R10 no reset", sys_rst, 0);
        warn_ie = 1'b0;
    endtask

    task automatic t_collide();
        wr_src(1'b0, 1'b0, 1'b0);
        tick(1);
        wr_src(1'b0, 1'b1, 1'b1);
        chk("R12 flash+sw rst", sys_rst, 1);
        chk("R12 flash beats sw", rst_cause, 3);
        tick(1);
        chk("R12 single pulse", sys_rst, 0);
        tick(8);
        chk("R11 cause kept idle", rst_cause, 3);
        wr_src(1'b1, 1'b0, 1'b0);
        tick(1);
        cmp_below_por = 1'b1;
        cmp_below_rst = 1'b1;
        tick(5);
        chk("R12 por+trip cause", rst_cause, 0);
        chk("R12 por delay on", por_dly_active, 1);
        cmp_below_por = 1'b0;
        cmp_below_rst = 1'b0;
        wait_idle();
        chk("R12 por cause final", rst_cause, 0);
    endtask

    initial begin
        for (int i = 0; i < 200000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        t_cold_reset();
        t_por_restart();
        t_mon_trip();
        t_sw_reset();
        t_sel_needs_en();
        t_flash_err();
        t_settle();
        t_flash_ok();
        t_sleep();
        t_warn();
        t_collide();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule